// File: doc/BRIEF.md
# Dual Phase Comparator with Lock Detect

This block is the phase-detection front end of an all-digital phase-locked loop. A reference input and a feedback input are sampled on a fast system clock. Each passes through a two-flop synchronizer and a rising-edge detector. Two error signals are produced from the synchronized inputs.

The first error signal is the exclusive-OR of the two synchronized levels. It suits 50% duty-cycle signals. A loop built on it settles with the two inputs a quarter period apart at centre frequency, and it can lock onto harmonics. The second error signal comes from an edge-sensing phase-frequency comparator. That comparator looks only at rising edges, drives the loop toward zero phase difference between those edges, and does not lock onto harmonics. Its three-state output is modelled as a drive-enable and a drive-value pair.

A lock qualifier watches the edge comparator. It raises a lock flag once a programmable number of consecutive comparisons have each resolved within one sample. A mode input chooses which comparator feeds the downstream loop filter.

The edge comparator is a three-state machine:
- `PD_IDLE`: output released, nothing pending.
- `PD_REF_LEAD`: a reference edge is pending; the output drives high.
- `PD_FB_LEAD`: a feedback edge is pending; the output drives low.

Its transitions are:
- idle to reference-lead on a reference edge alone;
- idle to feedback-lead on a feedback edge alone;
- reference-lead back to idle on a feedback edge alone;
- feedback-lead back to idle on a reference edge alone;
- every other edge combination holds the current state. This includes two edges in the same sample from idle, and two edges in the same sample while a lead is pending.

Top module: `dual_phase_detector`

## Requirements
- R1: `xor_err` is the exclusive-OR of the two inputs. An input level presented before clock edge k is reflected in `xor_err` after edge k+1.
- R2: When a reference rising edge is detected with no feedback edge pending or coincident, `pfd_en`=1 and `pfd_val`=1 (drive high). This holds until a feedback rising edge is detected alone.
- R3: When a feedback rising edge is detected first, `pfd_en`=1 and `pfd_val`=0 (drive low). This holds until a reference rising edge is detected alone.
- R4: Rising edges on both inputs in the same sample leave the comparator in its current state. From idle, the output stays released.
- R5: With nothing pending, `pfd_en`=0. Falling edges and duty cycle have no effect on `pfd_en`/`pfd_val`.
- R6: A rising edge presented before clock edge k changes `pfd_en`/`pfd_val` after clock edge k+2.
- R7: `lock_out` rises after LOCK_CYCLES consecutive good comparisons. A good comparison is either coincident edges from idle, or a lead state resolved after exactly one cycle.
- R8: A lead state held for a second cycle clears `lock_out` and the good-comparison count at the following clock edge.
- R9: With LOCK_CYCLES set to 1 or less, `lock_out` rises on the first good comparison.
- R10: With `mode_sel`=0, `loop_en`=1 and `loop_val`=`xor_err`. With `mode_sel`=1, `loop_en`/`loop_val` equal `pfd_en`/`pfd_val`.
- R11: Synchronous reset clears the synchronizers and pending edges, releases the edge comparator (`pfd_en`=0) and clears `lock_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| mode_sel | input | 1 | 0 selects the XOR comparator, 1 the edge comparator |
| xor_err | output | 1 | XOR comparator error |
| pfd_en | output | 1 | Edge comparator drive enable (0 = released) |
| pfd_val | output | 1 | Edge comparator drive value |
| lock_out | output | 1 | Qualified lock indication |
| loop_en | output | 1 | Selected error drive enable |
| loop_val | output | 1 | Selected error drive value |

## Verification
The bench builds two instances side by side. One has LOCK_CYCLES=4, so the debounce counter fills and saturates within a few waveform periods. The other has LOCK_CYCLES=1, which selects the undebounced generate branch. Both instances see the same waveforms, so they can be compared directly.

The stimulus covers several cases:
- square waves with zero and one-sample offsets, which should lock;
- wider offsets in both directions, which should drop lock;
- unequal duty cycles;
- coincident edges;
- a reset while a lead is pending;
- a random stretch with random mode selection and occasional resets.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic [1:0] {
        PD_IDLE     = 2'd0,
        PD_REF_LEAD = 2'd1,
        PD_FB_LEAD  = 2'd2
    } pd_state_e;
endpackage

// File: rtl/pd_input_sync.sv
module pd_input_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign level = chain_q[SYNC_STAGES-1];
    assign rise  = chain_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/pd_edge_fsm.sv
module pd_edge_fsm
    import pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_ref,
    input  logic      rise_fb,
    output pd_state_e state,
    output logic      drv_en,
    output logic      drv_val
);
    pd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (rise_ref && !rise_fb)      state_d = PD_REF_LEAD;
                else if (rise_fb && !rise_ref) state_d = PD_FB_LEAD;
            end
            PD_REF_LEAD: if (rise_fb && !rise_ref) state_d = PD_IDLE;
            PD_FB_LEAD:  if (rise_ref && !rise_fb) state_d = PD_IDLE;
            default:     state_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        drv_en  = 1'b0;
        drv_val = 1'b0;
        unique case (state_q)
            PD_IDLE:     begin drv_en = 1'b0; drv_val = 1'b0; end
            PD_REF_LEAD: begin drv_en = 1'b1; drv_val = 1'b1; end
            PD_FB_LEAD:  begin drv_en = 1'b1; drv_val = 1'b0; end
            default:     begin drv_en = 1'b0; drv_val = 1'b0; end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pd_lock_qual.sv
module pd_lock_qual
    import pd_pkg::*;
#(
    parameter int LOCK_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  pd_state_e state,
    input  logic      rise_ref,
    input  logic      rise_fb,
    output logic      stale,
    output logic      lock
);
    logic good_evt, bad_evt, resolving;
    logic stale_q, lock_q;

    assign resolving = ((state == PD_REF_LEAD) && rise_fb) ||
                       ((state == PD_FB_LEAD)  && rise_ref);
    assign good_evt  = ((state == PD_IDLE) && rise_ref && rise_fb) ||
                       (resolving && !stale_q);
    assign bad_evt   = (state != PD_IDLE) && stale_q;

    always_ff @(posedge clk) begin
        if (rst) stale_q <= 1'b0;
        else     stale_q <= (state != PD_IDLE) && !resolving;
    end

    generate
        if (LOCK_CYCLES <= 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst)           lock_q <= 1'b0;
                else if (bad_evt)  lock_q <= 1'b0;
                else if (good_evt) lock_q <= 1'b1;
            end
        end else begin : g_debounce
            localparam int CW = $clog2(LOCK_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);
            logic [CW-1:0] good_cnt_q;
            always_ff @(posedge clk) begin
                if (rst || bad_evt) begin
                    good_cnt_q <= '0;
                    lock_q     <= 1'b0;
                end else if (good_evt) begin
                    if (good_cnt_q == LAST) lock_q <= 1'b1;
                    else                    good_cnt_q <= good_cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign stale = stale_q;
    assign lock  = lock_q;
endmodule

// File: rtl/dual_phase_detector.sv
module dual_phase_detector
    import pd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    input  logic mode_sel,
    output logic xor_err,
    output logic pfd_en,
    output logic pfd_val,
    output logic lock_out,
    output logic loop_en,
    output logic loop_val
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_vec, level_vec, rise_vec;
    pd_state_e         cmp_state;
    logic              lock_stale;

    assign raw_vec = {fb_in, ref_in};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
        pd_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_vec[gi]),
            .level    (level_vec[gi]),
            .rise     (rise_vec[gi])
        );
    end

    assign xor_err = level_vec[0] ^ level_vec[1];

    pd_edge_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rise_ref (rise_vec[0]),
        .rise_fb  (rise_vec[1]),
        .state    (cmp_state),
        .drv_en   (pfd_en),
        .drv_val  (pfd_val)
    );

    pd_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .state    (cmp_state),
        .rise_ref (rise_vec[0]),
        .rise_fb  (rise_vec[1]),
        .stale    (lock_stale),
        .lock     (lock_out)
    );

    assign loop_en  = mode_sel ? pfd_en  : 1'b1;
    assign loop_val = mode_sel ? pfd_val : xor_err;
endmodule

// File: rtl/dual_phase_detector_chk.sv
module dual_phase_detector_chk (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic pfd_en,
    input logic pfd_val,
    input logic lock_out,
    input logic loop_en,
    input logic rise_ref,
    input logic rise_fb,
    input logic stale
);
    p_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
        (pfd_en && pfd_val && !rise_fb) |=> (pfd_en && pfd_val));

    p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
        (pfd_en && !pfd_val && !rise_ref) |=> (pfd_en && !pfd_val));

    p_coincident_r4: assert property (@(posedge clk) disable iff (rst)
        (!pfd_en && rise_ref && rise_fb) |=> !pfd_en);

    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!pfd_en && !rise_ref && !rise_fb) |=> !pfd_en);

    p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (pfd_en && stale) |=> !lock_out);

    p_xor_drive_r10: assert property (@(posedge clk) disable iff (rst)
        !mode_sel |-> loop_en);

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!pfd_en && !lock_out));
endmodule

bind dual_phase_detector dual_phase_detector_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .pfd_en   (pfd_en),
    .pfd_val  (pfd_val),
    .lock_out (lock_out),
    .loop_en  (loop_en),
    .rise_ref (rise_vec[0]),
    .rise_fb  (rise_vec[1]),
    .stale    (lock_stale)
);

// File: tb/test_dual_phase_detector.sv
module test_dual_phase_detector;
    localparam int CLK_PERIOD = 10;
    localparam int LC_SLOW    = 4;
    localparam int LC_FAST    = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, fb_in = 1'b0, mode_sel = 1'b0;
    logic xor_err, pfd_en, pfd_val, lock_out, loop_en, loop_val;
    logic f_xor, f_en, f_val, f_lock, f_len, f_lval;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_phase_detector #(.LOCK_CYCLES(LC_SLOW)) i_dual_phase_detector (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .mode_sel(mode_sel),
        .xor_err(xor_err), .pfd_en(pfd_en), .pfd_val(pfd_val), .lock_out(lock_out),
        .loop_en(loop_en), .loop_val(loop_val));

    dual_phase_detector #(.LOCK_CYCLES(LC_FAST)) i_dual_phase_detector_fast (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .mode_sel(mode_sel),
        .xor_err(f_xor), .pfd_en(f_en), .pfd_val(f_val), .lock_out(f_lock),
        .loop_en(f_len), .loop_val(f_lval));

    // bench reference model
    logic hr0, hr1, hr2, hf0, hf1, hf2;
    int   m_st;
    logic m_stale;
    int   m_cnt [2];
    logic m_lock [2];

    function automatic int lc_of(int j);
        return (j == 0) ? LC_SLOW : LC_FAST;
    endfunction

    function automatic logic exp_en();
        return m_st != 0;
    endfunction

    function automatic logic exp_val();
        return m_st == 1;
    endfunction

    task automatic model_step();
        logic rr, rf, good, bad, resolving;
        int   nst;
        if (rst) begin
            {hr0, hr1, hr2, hf0, hf1, hf2} = '0;
            m_st = 0; m_stale = 1'b0;
            for (int j = 0; j < 2; j++) begin m_cnt[j] = 0; m_lock[j] = 1'b0; end
            return;
        end
        rr = hr1 & ~hr2;
        rf = hf1 & ~hf2;
        good      = (m_st == 0 && rr && rf) || (m_st == 1 && rf && !m_stale) ||
                    (m_st == 2 && rr && !m_stale);
        bad       = (m_st != 0) && m_stale;
        resolving = (m_st == 1 && rf) || (m_st == 2 && rr);
        nst = m_st;
        case (m_st)
            0: if (rr && !rf) nst = 1; else if (rf && !rr) nst = 2;
            1: if (rf && !rr) nst = 0;
            default: if (rr && !rf) nst = 0;
        endcase
        for (int j = 0; j < 2; j++) begin
            if (bad) begin m_cnt[j] = 0; m_lock[j] = 1'b0; end
            else if (good) begin
                if (m_cnt[j] < lc_of(j)) m_cnt[j]++;
                m_lock[j] = (m_cnt[j] >= lc_of(j));
            end
        end
        m_stale = (m_st != 0) && !resolving;
        m_st = nst;
        hr2 = hr1; hr1 = hr0; hr0 = ref_in;
        hf2 = hf1; hf1 = hf0; hf0 = fb_in;
    endtask

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic ex_xor;
        ex_xor = hr1 ^ hf1;
        if (rst) begin
            chk("R11 pfd_en", pfd_en, 1'b0);
            chk("R11 lock", lock_out, 1'b0);
        end
        chk("R1 xor", xor_err, ex_xor);
        chk("R2 R3 R5 R6 pfd_en", pfd_en, exp_en());
        chk("R2 R3 R6 pfd_val", pfd_val, exp_val());
        chk("R7 R8 lock", lock_out, m_lock[0]);
        chk("R9 fast lock", f_lock, m_lock[1]);
        chk("R10 loop_en", loop_en, mode_sel ? exp_en() : 1'b1);
        chk("R10 loop_val", loop_val, mode_sel ? exp_val() : ex_xor);
    endtask

    task automatic tick(logic r, logic f, logic m, logic rs);
        ref_in = r; fb_in = f; mode_sel = m; rst = rs;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wave(int per, int dr, int df, int off, int n, logic m);
        for (int t = 0; t < per * n; t++)
            tick((t % per) < dr, ((t + per - off) % per) < df, m, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R11 reset state", pfd_en | lock_out | f_lock | xor_err, 1'b0);

        // R6: lone reference edge from idle: released after k+1, driving after k+2
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R6 not yet", pfd_en, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2 R6 drive high", pfd_en & pfd_val, 1'b1);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R2 held", pfd_en & pfd_val, 1'b1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 released by fb", pfd_en, 1'b0);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);

        // R4: coincident edges from idle
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 coincident stays released", pfd_en, 1'b0);

        // R7: aligned inputs lock
        wave(12, 6, 6, 0, 8, 1'b1);
        chk("R7 aligned lock", lock_out, 1'b1);
        chk("R9 fast aligned lock", f_lock, 1'b1);

        // R5/R7: one-sample lag, unequal duty keeps lock
        wave(12, 6, 2, 1, 6, 1'b1);
        chk("R5 R7 lock with duty skew", lock_out, 1'b1);

        // R8: wide lag drops lock
        wave(12, 6, 6, 4, 4, 1'b1);
        chk("R8 lag drops lock", lock_out, 1'b0);
        chk("R8 fast lag drops lock", f_lock, 1'b0);

        // R3: feedback leads
        wave(12, 5, 7, 9, 4, 1'b0);
        chk("R3 R8 fb lead no lock", lock_out, 1'b0);

        // R11: reset while a lead is pending
        wave(16, 8, 8, 5, 2, 1'b1);
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R11 mid reset release", pfd_en, 1'b0);

        // relock then random stretch
        wave(10, 3, 8, 0, 6, 1'b0);
        chk("R7 relock after reset", lock_out, 1'b1);
        for (int i = 0; i < 3000; i++)
            tick(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), ($urandom % 200) == 0);
        wave(20, 10, 4, 1, 6, 1'b1);
        chk("R7 final lock", lock_out, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule